// File: doc/BRIEF.md
# Multi-Thread Reset Cause Recorder

This block keeps a small record of the most recent reset that the chip-level reset logic reports to the core, and shows that record to software in every hardware thread. Three single-bit completion inputs stand for reset types 1, 2 and 3. Any one of them that is high on a clock edge gets captured. A level held for one cycle is enough, and no edge detection takes place. When several are high on the same edge, a fixed priority reduces them to a single 2-bit type code.

Each thread has two 2-bit fields. The recent-reset field always takes the captured code. The watchdog-cause field takes the code only when a qualifier input says a watchdog timer started the reset. Every thread's copy is written on the same edge. Software clears a thread's fields by writing ones to the bits it wants cleared. That clear touches only the selected thread. A capture on the same edge always beats a clear, so no reset event is lost. The core reset sets everything to zero. Completion inputs are ignored until the block has seen one clock edge out of reset.

Top module: `rststat_top`

## Requirements
- R1: A completion input that is high for a single clock edge after initialization is captured, and the new code appears on the field outputs right after that edge.
- R2: With several completion inputs high on one edge, type 3 (input bit 2) beats type 2 (bit 1), and type 2 beats type 1 (bit 0).
- R3: Recent-reset field encoding: 2'b00 means nothing recorded since the last clear, 2'b01 means type 1, 2'b10 means type 2, 2'b11 means type 3.
- R4: While the core reset (rst_n low) is asserted, both fields of every thread read 2'b00.
- R5: A capture writes the same code into every thread's copy on the same edge.
- R6: The watchdog-cause field uses the same codes as the recent-reset field, with 2'b00 meaning no watchdog reset. It takes the code only when wdogCause is high on the capture edge. Otherwise it keeps its value while the recent-reset field still updates.
- R7: On the first clock edge after rst_n rises, the completion inputs are ignored and the fields stay 2'b00.
- R8: Clear bits are write-one-to-clear per field bit. Thread t owns bits [2t+1:2t] of swClrRecent and swClrWdog. A 1 clears the matching output bit on the next edge, and other threads are unchanged.
- R9: When a capture and a clear of the same field happen on one edge, the field takes the captured code.
- R10: With no capture and no clear bit set, both fields hold their values. A completion input held high for several edges keeps writing the same code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Core reset, asynchronous, active low |
| rstDone | input | 3 | Reset-complete levels; bit 0 type 1, bit 1 type 2, bit 2 type 3 |
| wdogCause | input | 1 | High when the reported reset came from the watchdog timer |
| swClrRecent | input | 2*NumThreads | Write-one-to-clear bits for each thread's recent-reset field |
| swClrWdog | input | 2*NumThreads | Write-one-to-clear bits for each thread's watchdog-cause field |
| recentCode | output | 2*NumThreads | Recent-reset field of each thread, thread t at [2t+1:2t] |
| wdogCode | output | 2*NumThreads | Watchdog-cause field of each thread, thread t at [2t+1:2t] |

## Verification
Every field is a register that drives a port directly, so a wrong internal value shows up on the outputs one edge after the stimulus that caused it. A wrong priority, a missed watchdog qualifier, or a clear that reaches the wrong thread is visible right away. A thread copy that drifts from the others shows as a mismatch between output slices on the capture edge. A faulty initialization flag shows on the first edge after reset release, because an input held high there must leave the outputs at zero.

// File: rtl/rststat_pkg.sv
package rststat_pkg;

  localparam int NumTypes = 3;
  localparam int CodeW    = 2;

  typedef logic [CodeW-1:0] typeCode_t;

  typedef struct packed {
    logic      capRecent;
    logic      capWdog;
    typeCode_t code;
  } capStrobe_t;

  function automatic typeCode_t encodeType(input logic [NumTypes-1:0] levels);
    typeCode_t result;
    result = '0;
    for (int i = 0; i < NumTypes; i++) begin
      if (levels[i]) result = typeCode_t'(i + 1);
    end
    return result;
  endfunction

endpackage

// File: rtl/rststat_ctrl.sv
module rststat_ctrl
  import rststat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NumTypes-1:0] rstDone,
  input  logic                wdogCause,
  output capStrobe_t          strobe
);

  logic armed;
  logic anyDone;
  typeCode_t winner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign anyDone = |rstDone;
  assign winner  = encodeType(rstDone);

  always_comb begin
    strobe           = '0;
    strobe.capRecent = armed && anyDone;
    strobe.capWdog   = armed && anyDone && wdogCause;
    strobe.code      = winner;
  end

endmodule

// File: rtl/rststat_field.sv
module rststat_field
  import rststat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      capture,
  input  typeCode_t capCode,
  input  typeCode_t clrBits,
  output typeCode_t value
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value <= '0;
    else if (capture) value <= capCode;
    else              value <= value & ~clrBits;
  end

endmodule

// File: rtl/rststat_datapath.sv
module rststat_datapath
  import rststat_pkg::*;
#(
  parameter int NumThreads = 4,
  localparam int FieldW    = NumThreads * CodeW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  capStrobe_t        strobe,
  input  logic [FieldW-1:0] swClrRecent,
  input  logic [FieldW-1:0] swClrWdog,
  output logic [FieldW-1:0] recentCode,
  output logic [FieldW-1:0] wdogCode
);

  for (genvar t = 0; t < NumThreads; t++) begin : g_thread
    rststat_field recent_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (strobe.capRecent),
      .capCode (strobe.code),
      .clrBits (swClrRecent[t*CodeW +: CodeW]),
      .value   (recentCode[t*CodeW +: CodeW])
    );
    rststat_field wdog_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (strobe.capWdog),
      .capCode (strobe.code),
      .clrBits (swClrWdog[t*CodeW +: CodeW]),
      .value   (wdogCode[t*CodeW +: CodeW])
    );
  end

endmodule

// File: rtl/rststat_top.sv
module rststat_top
  import rststat_pkg::*;
#(
  parameter int NumThreads = 4,
  localparam int FieldW    = NumThreads * CodeW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NumTypes-1:0] rstDone,
  input  logic                wdogCause,
  input  logic [FieldW-1:0]   swClrRecent,
  input  logic [FieldW-1:0]   swClrWdog,
  output logic [FieldW-1:0]   recentCode,
  output logic [FieldW-1:0]   wdogCode
);

  capStrobe_t strobe;

  rststat_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rstDone   (rstDone),
    .wdogCause (wdogCause),
    .strobe    (strobe)
  );

  rststat_datapath #(.NumThreads(NumThreads)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .swClrRecent (swClrRecent),
    .swClrWdog   (swClrWdog),
    .recentCode  (recentCode),
    .wdogCode    (wdogCode)
  );

endmodule

// File: rtl/rststat_checker.sv
module rststat_checker
  import rststat_pkg::*;
#(
  parameter int NumThreads = 4,
  localparam int FieldW    = NumThreads * CodeW
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NumTypes-1:0] rstDone,
  input logic                wdogCause,
  input logic [FieldW-1:0]   swClrRecent,
  input logic [FieldW-1:0]   swClrWdog,
  input logic [FieldW-1:0]   recentCode,
  input logic [FieldW-1:0]   wdogCode
);

  logic seenEdge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seenEdge <= 1'b0;
    else        seenEdge <= 1'b1;
  end

  function automatic logic allAre(input logic [FieldW-1:0] vec, input typeCode_t c);
    logic ok;
    ok = 1'b1;
    for (int t = 0; t < NumThreads; t++) begin
      if (vec[t*CodeW +: CodeW] != c) ok = 1'b0;
    end
    return ok;
  endfunction

  // R2: type 3 wins whenever its input is high
  a_r2_type3_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (seenEdge && rstDone[2]) |=> allAre(recentCode, 2'b11));

  // R2: type 2 beats type 1 when type 3 is absent
  a_r2_type2_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (seenEdge && !rstDone[2] && rstDone[1]) |=> allAre(recentCode, 2'b10));

  // R5: all copies agree after a capture
  a_r5_copies_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (seenEdge && rstDone == 3'b001) |=> allAre(recentCode, 2'b01));

  // R6: the watchdog field holds without the qualifier
  a_r6_wdog_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (seenEdge && !wdogCause && swClrWdog == '0) |=> $stable(wdogCode));

  // R7: inputs ignored on the first edge out of reset
  a_r7_init_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    !seenEdge |=> (recentCode == '0 && wdogCode == '0));

  // R8: a full clear with no capture empties the recent field
  a_r8_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rstDone == '0 && swClrRecent == '1) |=> recentCode == '0);

  // R9: capture wins over a same-edge clear
  a_r9_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (seenEdge && rstDone[2] && wdogCause && swClrWdog == '1) |=> allAre(wdogCode, 2'b11));

  // R10: idle edges leave the recent field unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seenEdge && rstDone == '0 && swClrRecent == '0) |=> $stable(recentCode));

endmodule

bind rststat_top rststat_checker #(.NumThreads(NumThreads)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rstDone     (rstDone),
  .wdogCause   (wdogCause),
  .swClrRecent (swClrRecent),
  .swClrWdog   (swClrWdog),
  .recentCode  (recentCode),
  .wdogCode    (wdogCode)
);

// File: tb/rststat_top_tb_top.sv
module rststat_top_tb_top;

  localparam int NT = 4;
  localparam int FW = NT * 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    rstDone = '0;
  logic          wdogCause = 1'b0;
  logic [FW-1:0] swClrRecent = '0;
  logic [FW-1:0] swClrWdog = '0;
  logic [FW-1:0] recentCode;
  logic [FW-1:0] wdogCode;

  int checks = 0;
  int errors = 0;

  int refRecent[NT];
  int refWdog[NT];
  bit refArmed = 0;

  always #4 clk = ~clk;

  rststat_top #(.NumThreads(NT)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rstDone     (rstDone),
    .wdogCause   (wdogCause),
    .swClrRecent (swClrRecent),
    .swClrWdog   (swClrWdog),
    .recentCode  (recentCode),
    .wdogCode    (wdogCode)
  );

  task automatic checkOne(input string tag, input string what, input int thr,
                          input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s thread %0d actual %0d expected %0d", tag, what, thr, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    for (int t = 0; t < NT; t++) begin
      checkOne(tag, "recent", t, int'(recentCode[t*2 +: 2]), refRecent[t]);
      checkOne(tag, "wdog", t, int'(wdogCode[t*2 +: 2]), refWdog[t]);
    end
  endtask

  task automatic modelEdge();
    int code;
    if (!rst_n) begin
      refArmed = 0;
      for (int t = 0; t < NT; t++) begin refRecent[t] = 0; refWdog[t] = 0; end
      return;
    end
    code = rstDone[2] ? 3 : rstDone[1] ? 2 : rstDone[0] ? 1 : 0;
    for (int t = 0; t < NT; t++) begin
      int cr = int'(swClrRecent[t*2 +: 2]);
      int cw = int'(swClrWdog[t*2 +: 2]);
      if (refArmed && code != 0) refRecent[t] = code;
      else refRecent[t] = refRecent[t] & ~cr & 3;
      if (refArmed && code != 0 && wdogCause) refWdog[t] = code;
      else refWdog[t] = refWdog[t] & ~cw & 3;
    end
    refArmed = 1;
  endtask

  task automatic step(input logic rn, input logic [2:0] r, input logic w,
                      input logic [FW-1:0] cr, input logic [FW-1:0] cw,
                      input string tag);
    @(negedge clk);
    rst_n = rn; rstDone = r; wdogCause = w; swClrRecent = cr; swClrWdog = cw;
    if (!rn) modelEdge();
    @(posedge clk);
    modelEdge();
    #1;
    compareAll(tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) begin refRecent[t] = 0; refWdog[t] = 0; end
    // R4: reset state
    step(1'b0, 3'b000, 1'b0, '0, '0, "R4");
    step(1'b0, 3'b111, 1'b1, '0, '0, "R4");
    // R7: inputs high on first edge out of reset are ignored
    step(1'b1, 3'b111, 1'b1, '0, '0, "R7");
    step(1'b1, 3'b000, 1'b0, '0, '0, "R10");
    // R1 R3 R5: single-cycle pulses of each type
    step(1'b1, 3'b001, 1'b0, '0, '0, "R1");
    step(1'b1, 3'b000, 1'b0, '0, '0, "R10");
    step(1'b1, 3'b010, 1'b0, '0, '0, "R3");
    step(1'b1, 3'b100, 1'b0, '0, '0, "R5");
    // R2: simultaneous pulses
    step(1'b1, 3'b011, 1'b0, '0, '0, "R2");
    step(1'b1, 3'b111, 1'b0, '0, '0, "R2");
    step(1'b1, 3'b101, 1'b0, '0, '0, "R2");
    step(1'b1, 3'b011, 1'b0, '0, '0, "R2");
    // R6: watchdog qualifier
    step(1'b1, 3'b001, 1'b1, '0, '0, "R6");
    step(1'b1, 3'b100, 1'b0, '0, '0, "R6");
    step(1'b1, 3'b010, 1'b1, '0, '0, "R6");
    // R10: held level recaptures the same code
    step(1'b1, 3'b010, 1'b1, '0, '0, "R10");
    step(1'b1, 3'b010, 1'b1, '0, '0, "R10");
    step(1'b1, 3'b000, 1'b0, '0, '0, "R10");
    // R8: clears confined to one thread and to selected bits
    step(1'b1, 3'b000, 1'b0, 8'b0000_1100, '0, "R8");
    step(1'b1, 3'b000, 1'b0, '0, 8'b0010_0000, "R8");
    step(1'b1, 3'b100, 1'b1, '0, '0, "R8");
    step(1'b1, 3'b000, 1'b0, 8'b0100_0001, 8'b1100_0010, "R8");
    step(1'b1, 3'b000, 1'b0, 8'hFF, 8'hFF, "R8");
    // R9: capture beats a same-edge clear
    step(1'b1, 3'b100, 1'b1, 8'hFF, 8'hFF, "R9");
    step(1'b1, 3'b001, 1'b0, 8'hFF, 8'hFF, "R9");
    step(1'b1, 3'b010, 1'b0, 8'h00, 8'hFF, "R9");
    // back-to-back pulses of differing types
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 3'((i % 7) + 1), 1'(i % 2), 8'(i * 37), 8'(i * 53), "R1");
    end
    // R4: reset mid-run clears everything, R7 again after release
    step(1'b0, 3'b100, 1'b1, '0, '0, "R4");
    step(1'b1, 3'b100, 1'b1, '0, '0, "R7");
    step(1'b1, 3'b001, 1'b1, '0, '0, "R1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule